// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one input clock and produces two divided clocks, each with its own selectable ratio. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth of the input rate. Every output comes with a complement. All division comes from a single counter that wraps over the least common multiple of the ratios. As a result, the edges that the two banks share always occur on the same rising input edge.

Divider activity is gated by an active-high hold request. The hold request is captured on the falling input edge, so the gate can only open or close while the input clock is low, and no shortened pulse can reach the counter. An asynchronous master reset drives every output low at once. Reset is released on a falling input edge, so several instances reset together start in lockstep. A ratio select that changes during a period is applied only at the next wrap of the shared counter. Because of this, no output pulse is ever shorter than half of its new period.

Top module: `ratio_divider_dual`

## Requirements
- R1: With `sel_a` = 0, `out_a` divides by 2. With `sel_a` = 1, it divides by 4. The duty cycle is 50% in both cases. Within each 12-edge counter period, `out_a` is high on the first half of every ratio-length group of enabled rising edges, starting with the edge at counter index 0.
- R2: With `sel_b` = 0, `out_b` divides by 4. With `sel_b` = 1, it divides by 6 (three edges high, three edges low). The same phase rule as R1 applies.
- R3: Both outputs are high at counter index 0 of every period, so their shared rising edges fall on the same input edge. After reset, the first rising edge of both outputs happens on the same input edge.
- R4: While the registered hold is high, every rising edge leaves all outputs unchanged. When hold returns low, division resumes from the exact point where it stopped.
- R5: `hold_req` is captured only on the falling input edge. A pulse on `hold_req` that starts and ends while the clock is high has no effect on the outputs.
- R6: Asserting `rst_in` drives `out_a` and `out_b` low and their complements high immediately, without waiting for a clock edge.
- R7: After `rst_in` falls, internal reset ends at the next falling edge. The hold request is captured at the falling edge after that. With `hold_req` low, the outputs stay low on the first rising edge after `rst_in` falls and go high on the second.
- R8: A select change made before the edge that wraps the counter takes effect on that wrap edge. A change made at any other time takes effect at the next wrap. Until then, the old ratio continues unchanged.
- R9: `out_a_n` and `out_b_n` are always the exact inverses of `out_a` and `out_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_in | input | 1 | Asynchronous master reset, active high |
| hold_req | input | 1 | Hold request, active high, captured on the falling clock edge |
| sel_a | input | 1 | Bank A ratio select (0: divide by 2, 1: divide by 4) |
| sel_b | input | 1 | Bank B ratio select (0: divide by 4, 1: divide by 6) |
| out_a | output | 1 | Bank A divided clock |
| out_a_n | output | 1 | Complement of out_a |
| out_b | output | 1 | Bank B divided clock |
| out_b_n | output | 1 | Complement of out_b |

## Verification
Two events can fall on the same rising edge: a ratio-select update and the wrap of the shared counter. To provoke this, the bench changes both selects immediately after the last index of a period. It then expects the new ratios to appear on the very next edge, at index 0. It also changes the selects in the middle of a period and expects the old ratios to continue until the wrap. A second collision is a hold request that toggles while the clock is high. This is judged by checking that the divided sequence continues without a gap.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    // Per-bank registered state: active ratio select and divided output
    typedef struct packed {
        logic sel;
        logic out;
    } bank_state_t;

endpackage

// File: rtl/rdiv_gate.sv
module rdiv_gate (
    input  logic clk_in,
    input  logic rst_in,
    input  logic hold_req,
    output logic rst_int,
    output logic hold_q
);
    logic rst_d, rst_q;
    logic hold_d, hold_r;

    always_comb begin
        rst_d  = 1'b0;
        hold_d = hold_req;
    end

    // Reset asserts at once and is released on a falling edge
    always_ff @(negedge clk_in or posedge rst_in) begin
        if (rst_in) rst_q <= 1'b1;
        else        rst_q <= rst_d;
    end

    // Hold capture on the falling edge, reset to the hold (safe) value
    always_ff @(negedge clk_in or posedge rst_q) begin
        if (rst_q) hold_r <= 1'b1;
        else       hold_r <= hold_d;
    end

    assign rst_int = rst_q;
    assign hold_q  = hold_r;
endmodule

// File: rtl/rdiv_count.sv
module rdiv_count #(
    parameter int PERIOD = 12,
    parameter int CNT_W  = 4
) (
    input  logic             clk_in,
    input  logic             rst_int,
    input  logic             hold_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             advance,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        advance = !hold_q;
        wrap    = advance && (st_q.cnt == LAST);
        if (advance) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    // Preset to the last index so the first enabled edge lands on index 0
    always_ff @(posedge clk_in or posedge rst_int) begin
        if (rst_int) st_q.cnt <= LAST;
        else         st_q     <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;

    AST_CNT_RANGE: assert property (@(posedge clk_in) disable iff (rst_int)
        cnt_q <= LAST); // R3

    AST_HOLD_FREEZE: assert property (@(posedge clk_in) disable iff (rst_int)
        hold_q |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/rdiv_bank.sv
module rdiv_bank
    import ratio_div_pkg::*;
#(
    parameter int R_LO  = 2,
    parameter int R_HI  = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk_in,
    input  logic             rst_int,
    input  logic             advance,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             sel_in,
    output logic             out_q
);
    localparam int HALF_LO = R_LO / 2;
    localparam int HALF_HI = R_HI / 2;

    bank_state_t st_d, st_q;
    logic [31:0] cnt_ext;
    logic        ph_lo, ph_hi;

    always_comb begin
        cnt_ext = 32'(cnt_d);
        ph_lo   = (cnt_ext % 32'(R_LO)) < 32'(HALF_LO);
        ph_hi   = (cnt_ext % 32'(R_HI)) < 32'(HALF_HI);
        st_d    = st_q;
        // Ratio select only moves at the shared wrap boundary
        if (wrap) st_d.sel = sel_in;
        if (advance) st_d.out = st_d.sel ? ph_hi : ph_lo;
    end

    always_ff @(posedge clk_in or posedge rst_int) begin
        if (rst_int) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_q = st_q.out;

    AST_OUT_FREEZE: assert property (@(posedge clk_in) disable iff (rst_int)
        !advance |=> $stable(out_q)); // R4
endmodule

// File: rtl/ratio_divider_dual.sv
module ratio_divider_dual
    import ratio_div_pkg::*;
#(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_LO = 4,
    parameter int B_HI = 6
) (
    input  logic clk_in,
    input  logic rst_in,
    input  logic hold_req,
    input  logic sel_a,
    input  logic sel_b,
    output logic out_a,
    output logic out_a_n,
    output logic out_b,
    output logic out_b_n
);
    localparam int NUM_BANKS = 2;
    localparam int PERIOD    = lcm_f(lcm_f(A_LO, A_HI), lcm_f(B_LO, B_HI));
    localparam int CNT_W     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int LO_TAB [NUM_BANKS] = '{A_LO, B_LO};
    localparam int HI_TAB [NUM_BANKS] = '{A_HI, B_HI};

    logic                 rst_int;
    logic                 hold_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cnt_d;
    logic                 advance;
    logic                 wrap;
    logic [NUM_BANKS-1:0] sel_vec;
    logic [NUM_BANKS-1:0] out_vec;

    assign sel_vec = {sel_b, sel_a};

    rdiv_gate u_gate (
        .clk_in   (clk_in),
        .rst_in   (rst_in),
        .hold_req (hold_req),
        .rst_int  (rst_int),
        .hold_q   (hold_q)
    );

    rdiv_count #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_count (
        .clk_in  (clk_in),
        .rst_int (rst_int),
        .hold_q  (hold_q),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d),
        .advance (advance),
        .wrap    (wrap)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        rdiv_bank #(
            .R_LO  (LO_TAB[g]),
            .R_HI  (HI_TAB[g]),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk_in  (clk_in),
            .rst_int (rst_int),
            .advance (advance),
            .wrap    (wrap),
            .cnt_d   (cnt_d),
            .sel_in  (sel_vec[g]),
            .out_q   (out_vec[g])
        );
    end

    assign out_a   = out_vec[0];
    assign out_a_n = ~out_vec[0];
    assign out_b   = out_vec[1];
    assign out_b_n = ~out_vec[1];

    AST_ALIGN_HIGH: assert property (@(posedge clk_in) disable iff (rst_int)
        (cnt_q == '0) |-> (out_vec == {NUM_BANKS{1'b1}})); // R3

    AST_RST_CLEAR: assert property (@(posedge clk_in)
        rst_in |-> (out_vec == '0)); // R6
endmodule

// File: tb/ratio_divider_dual_bench.sv
module ratio_divider_dual_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PER = 12;

    logic clk = 1'b0;
    logic rst_in, hold_req, sel_a, sel_b;
    logic out_a, out_a_n, out_b, out_b_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    ratio_divider_dual u_ratio_divider_dual (
        .clk_in   (clk),
        .rst_in   (rst_in),
        .hold_req (hold_req),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .out_a    (out_a),
        .out_a_n  (out_a_n),
        .out_b    (out_b),
        .out_b_n  (out_b_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {sel_a, sel_b, pattern A, pattern B}; bit 11 is counter index 0
    localparam logic [25:0] VEC [4] = '{
        {1'b0, 1'b0, 12'b101010101010, 12'b110011001100},
        {1'b1, 1'b0, 12'b110011001100, 12'b110011001100},
        {1'b0, 1'b1, 12'b101010101010, 12'b111000111000},
        {1'b1, 1'b1, 12'b110011001100, 12'b111000111000}
    };

    function automatic logic [3:0] mk(input logic a, input logic b);
        return {a, ~a, b, ~b};
    endfunction

    function automatic logic pat(input int r, input int idx);
        return (idx % r) < (r / 2);
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {out_a, out_a_n, out_b, out_b_n};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input string req, input logic a, input logic b);
        @(posedge clk);
        #2;
        check(req, mk(a, b));
    endtask

    task automatic run_idx(input string req, input int ra, input int rb,
                           input int from, input int count);
        for (int k = 0; k < count; k++) begin
            step(req, pat(ra, (from + k) % PER), pat(rb, (from + k) % PER));
        end
    endtask

    // Reset, release, and check the two-edge start latency (next step = index 0)
    task automatic start(input logic sa, input logic sb);
        rst_in   = 1'b1;
        hold_req = 1'b0;
        sel_a    = sa;
        sel_b    = sb;
        #1;
        check("R6 R9 reset state", mk(1'b0, 1'b0));
        @(posedge clk);
        #1;
        rst_in = 1'b0;
        @(posedge clk);
        #2;
        check("R7 first edge after release still low", mk(1'b0, 1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_in   = 1'b1;
        hold_req = 1'b0;
        sel_a    = 1'b0;
        sel_b    = 1'b0;
        #3;
        check("R6 reset state at time zero", mk(1'b0, 1'b0));

        // Vector table: every select combination, two full periods
        for (int v = 0; v < 4; v++) begin
            start(VEC[v][25], VEC[v][24]);
            for (int i = 0; i < 2 * PER; i++) begin
                step("R1 R2 R3 R9 ratio pattern",
                     VEC[v][23 - (i % PER)], VEC[v][11 - (i % PER)]);
            end
        end

        // R4: hold freezes outputs, resume continues the sequence
        start(1'b1, 1'b1);
        run_idx("R4 before hold", 4, 6, 0, 5);
        hold_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step("R4 held", pat(4, 4), pat(6, 4));
        end
        hold_req = 1'b0;
        run_idx("R4 resumed", 4, 6, 5, 11);

        // R5: hold pulse entirely inside the clock-high phase is ignored
        hold_req = 1'b1;
        #1;
        hold_req = 1'b0;
        run_idx("R5 high-phase pulse ignored", 4, 6, 16, 6);

        // R8: select change mid-period waits for the wrap
        start(1'b0, 1'b0);
        run_idx("R8 old ratio", 2, 4, 0, 3);
        sel_a = 1'b1;
        sel_b = 1'b1;
        run_idx("R8 old ratio until wrap", 2, 4, 3, 9);
        run_idx("R8 new ratio after wrap", 4, 6, 0, 12);
        // R8: change right before the wrap edge applies on that edge
        sel_a = 1'b0;
        sel_b = 1'b0;
        run_idx("R8 change coincides with wrap", 2, 4, 0, 6);

        // R6: asynchronous reset while clock is high
        rst_in = 1'b1;
        #1;
        check("R6 async reset mid-cycle", mk(1'b0, 1'b0));
        step("R6 held in reset", 1'b0, 1'b0);

        // R7 / R3: release with hold asserted, then first common rise
        hold_req = 1'b1;
        #1;
        rst_in = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step("R7 held after release", 1'b0, 1'b0);
        end
        hold_req = 1'b0;
        step("R3 both first rises together", 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule